// File: doc/BRIEF.md
# Self-checking configuration register bank with complement shadows

This block keeps a small set of device configuration registers and checks itself for corruption. Each register is stored twice: once as its true value and once as the bitwise complement of that value. At power-up the bank is filled from a stream of configuration words read out of nonvolatile program memory. Each word carries a register index, and every write sets both copies at once. A load-done strobe then closes the loading phase.

Once loading has closed, a comparator checks every register against its complement copy on every clock cycle, whether or not anything reads the register. A disagreement in any bit, such as one left by a single-cell upset, raises a sticky error flag and a sticky reset request for the chip's reset controller. Both stay high until the bank's own synchronous reset clears them. The parallel configuration outputs come straight from the value flops. A test-only port can invert any one bit of either copy, so that detection can be shown for every bit position.

Top module: `cfg_shadow_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every value copy is cleared to zero, every complement copy is set to all ones, loading is reopened, and `cfg_err` and `rst_req` are low from the next cycle on.
- R2: A load (`ld_valid` high) made before load-done, with `ld_index` below NUM_REGS, writes `ld_data` into register `ld_index`. The new value appears at the edge on `cfg_out[ld_index*REG_W +: REG_W]`, and the complement copy receives `~ld_data`.
- R3: A load whose `ld_index` is NUM_REGS or above changes no register.
- R4: After `ld_done` has been high at an edge, later loads change no register until the next reset.
- R5: A bank whose copies have been written only through the load port never raises `cfg_err` or `rst_req`.
- R6: After load-done, inverting any single bit of either copy through the test port (`tst_copy` 0 = value copy, 1 = complement copy) raises both `cfg_err` and `rst_req` at the clock edge that follows the edge that stored the corruption.
- R7: Once raised, `cfg_err` and `rst_req` stay high until reset, even if the corrupted bit is restored.
- R8: A corruption made before load-done is not reported while loading is open. It raises both flags one edge after loading closes.
- R9: A test inversion of the value copy changes the same bit of `cfg_out` at that edge. An inversion of the complement copy leaves `cfg_out` unchanged.
- R10: Asserting `rst` after an error clears both flags and returns `cfg_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Configuration word valid |
| ld_index | input | IDX_W | Target register index |
| ld_data | input | REG_W | Configuration word |
| ld_done | input | 1 | Ends loading and starts checking |
| tst_flip | input | 1 | Test only: invert one stored bit |
| tst_reg | input | IDX_W | Test only: register to corrupt |
| tst_bit | input | BIT_W | Test only: bit position to invert |
| tst_copy | input | 1 | Test only: 0 value copy, 1 complement copy |
| cfg_out | output | NUM_REGS*REG_W | Parallel configuration values, register i at bits i*REG_W upward |
| cfg_err | output | 1 | Sticky integrity error |
| rst_req | output | 1 | Sticky device reset request |

## Verification
The bench builds the block with its defaults: three registers of 16 bits. Three is not a power of two, so the two-bit index can carry the value 3. That is an address with no register behind it, which makes the out-of-range load case reachable. With 16-bit registers and two copies, a full sweep injects each of the 96 possible single-bit upsets on its own freshly loaded bank. The test port also makes it possible to place an upset before load-done and to undo one after it has been flagged.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
  typedef enum logic {
    COPY_VAL = 1'b0,
    COPY_SHD = 1'b1
  } copy_sel_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cfg_cell.sv
module cfg_cell
  import cfg_shadow_pkg::*;
#(
  parameter int W = 16,
  localparam int BW = idx_width(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  input  logic          flip_en,
  input  copy_sel_e     flip_copy,
  input  logic [BW-1:0] flip_bit,
  output logic [W-1:0]  val_q,
  output logic [W-1:0]  shd_q
);
  logic [W-1:0] mask;
  logic [W-1:0] val_d;
  logic [W-1:0] shd_d;

  always_comb begin
    mask  = flip_en ? (W'(1) << flip_bit) : '0;
    val_d = we ? wdata  : val_q;
    shd_d = we ? ~wdata : shd_q;
    if (flip_copy == COPY_VAL) val_d = val_d ^ mask;
    else                       shd_d = shd_d ^ mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      shd_q <= '1;
    end else begin
      val_q <= val_d;
      shd_q <= shd_d;
    end
  end

  // R2
  load_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !flip_en) |=> (shd_q == ~val_q));

  // R6
  single_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (flip_en && !we && (32'(flip_bit) < W)) |=>
      ($countones({val_q ^ $past(val_q), shd_q ^ $past(shd_q)}) == 1));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!we && !flip_en) |=> ($stable(val_q) && $stable(shd_q)));
endmodule

// File: rtl/cfg_cmp.sv
module cfg_cmp #(
  parameter int N = 3,
  parameter int W = 16
) (
  input  logic           en,
  input  logic [N*W-1:0] val_flat,
  input  logic [N*W-1:0] shd_flat,
  output logic           mismatch
);
  logic [N-1:0] reg_bad;

  for (genvar i = 0; i < N; i++) begin : g_reg
    assign reg_bad[i] = |(val_flat[i*W +: W] ^ ~shd_flat[i*W +: W]);
  end

  assign mismatch = en & (|reg_bad);
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
  import cfg_shadow_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int REG_W    = 16,
  localparam int IDX_W   = idx_width(NUM_REGS),
  localparam int BIT_W   = idx_width(REG_W)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld_valid,
  input  logic [IDX_W-1:0]          ld_index,
  input  logic [REG_W-1:0]          ld_data,
  input  logic                      ld_done,
  input  logic                      tst_flip,
  input  logic [IDX_W-1:0]          tst_reg,
  input  logic [BIT_W-1:0]          tst_bit,
  input  logic                      tst_copy,
  output logic [NUM_REGS*REG_W-1:0] cfg_out,
  output logic                      cfg_err,
  output logic                      rst_req
);
  logic                      armed_q;
  logic                      mismatch;
  logic [NUM_REGS*REG_W-1:0] val_flat;
  logic [NUM_REGS*REG_W-1:0] shd_flat;
  logic                      ld_ok;

  assign ld_ok = ld_valid && !armed_q && (32'(ld_index) < NUM_REGS);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
    logic we_i;
    logic flip_i;
    assign we_i   = ld_ok && (32'(ld_index) == i);
    assign flip_i = tst_flip && (32'(tst_reg) == i);

    cfg_cell #(.W(REG_W)) i_cell (
      .clk      (clk),
      .rst      (rst),
      .we       (we_i),
      .wdata    (ld_data),
      .flip_en  (flip_i),
      .flip_copy(copy_sel_e'(tst_copy)),
      .flip_bit (tst_bit),
      .val_q    (val_flat[i*REG_W +: REG_W]),
      .shd_q    (shd_flat[i*REG_W +: REG_W])
    );
  end

  cfg_cmp #(.N(NUM_REGS), .W(REG_W)) i_cmp (
    .en      (armed_q),
    .val_flat(val_flat),
    .shd_flat(shd_flat),
    .mismatch(mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cfg_err <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (ld_done) armed_q <= 1'b1;
      if (mismatch) begin
        cfg_err <= 1'b1;
        rst_req <= 1'b1;
      end
    end
  end

  assign cfg_out = val_flat;

  // R4
  armed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q |=> armed_q);

  // R8
  quiet_while_loading_chk: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> !cfg_err);

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err) |-> $past(mismatch));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> (cfg_err && rst_req));

  // R6
  flags_agree_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err == rst_req);
endmodule

// File: tb/test_cfg_shadow_bank.sv
module test_cfg_shadow_bank;
  localparam int NR = 3;
  localparam int RW = 16;
  localparam int IW = 2;
  localparam int BW = 4;
  localparam int NV = 6;

  // {index, data}; index 3 has no register behind it
  localparam logic [IW+RW-1:0] LD_TAB [NV] = '{
    {2'd0, 16'hA5C3},
    {2'd1, 16'h0F0F},
    {2'd2, 16'hFFFF},
    {2'd3, 16'h1234},
    {2'd1, 16'h8001},
    {2'd0, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_valid = 1'b0;
  logic [IW-1:0] ld_index = '0;
  logic [RW-1:0] ld_data = '0;
  logic ld_done = 1'b0;
  logic tst_flip = 1'b0;
  logic [IW-1:0] tst_reg = '0;
  logic [BW-1:0] tst_bit = '0;
  logic tst_copy = 1'b0;
  logic [NR*RW-1:0] cfg_out;
  logic cfg_err;
  logic rst_req;

  logic [RW-1:0] exp_v [NR];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_shadow_bank #(.NUM_REGS(NR), .REG_W(RW)) i_cfg_shadow_bank (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_index(ld_index),
    .ld_data(ld_data), .ld_done(ld_done), .tst_flip(tst_flip),
    .tst_reg(tst_reg), .tst_bit(tst_bit), .tst_copy(tst_copy),
    .cfg_out(cfg_out), .cfg_err(cfg_err), .rst_req(rst_req)
  );

  function automatic logic [NR*RW-1:0] exp_flat();
    logic [NR*RW-1:0] f;
    for (int i = 0; i < NR; i++) f[i*RW +: RW] = exp_v[i];
    return f;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    for (int i = 0; i < NR; i++) exp_v[i] = '0;
  endtask

  task automatic load(input logic [IW-1:0] idx, input logic [RW-1:0] d);
    ld_valid = 1'b1;
    ld_index = idx;
    ld_data  = d;
    step();
    ld_valid = 1'b0;
  endtask

  task automatic close_load();
    ld_done = 1'b1;
    step();
    ld_done = 1'b0;
  endtask

  task automatic flip(input int r, input int b, input bit c);
    tst_flip = 1'b1;
    tst_reg  = IW'(r);
    tst_bit  = BW'(b);
    tst_copy = c;
    step();
    tst_flip = 1'b0;
  endtask

  task automatic std_load();
    load(2'd0, 16'h3C5A);
    load(2'd1, 16'hF00D);
    load(2'd2, 16'h0001);
    exp_v[0] = 16'h3C5A;
    exp_v[1] = 16'hF00D;
    exp_v[2] = 16'h0001;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 cfg_out", 64'(cfg_out), 64'(0));
    chk("R1 cfg_err", 64'(cfg_err), 64'(0));
    chk("R1 rst_req", 64'(rst_req), 64'(0));

    // R2 / R3 table walk
    for (int v = 0; v < NV; v++) begin
      logic [IW-1:0] idx;
      logic [RW-1:0] d;
      {idx, d} = LD_TAB[v];
      load(idx, d);
      if (int'(idx) < NR) begin
        exp_v[idx] = d;
        chk("R2 load", 64'(cfg_out), 64'(exp_flat()));
      end else begin
        chk("R3 out-of-range", 64'(cfg_out), 64'(exp_flat()));
      end
    end

    // R5 clean bank stays quiet after arming
    close_load();
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R5 cfg_err", 64'(cfg_err), 64'(0));
      chk("R5 rst_req", 64'(rst_req), 64'(0));
    end

    // R4 loads after done are ignored
    load(2'd0, 16'hDEAD);
    load(2'd2, 16'hBEEF);
    chk("R4 locked", 64'(cfg_out), 64'(exp_flat()));
    step();
    chk("R4 no error", 64'(cfg_err), 64'(0));

    // R6 / R9 every bit of every copy
    for (int r = 0; r < NR; r++) begin
      for (int b = 0; b < RW; b++) begin
        for (int c = 0; c < 2; c++) begin
          do_reset();
          std_load();
          close_load();
          step();
          flip(r, b, c[0]);
          chk("R6 not yet", 64'(cfg_err), 64'(0));
          if (c == 0) exp_v[r][b] = ~exp_v[r][b];
          chk("R9 cfg_out", 64'(cfg_out), 64'(exp_flat()));
          step();
          chk("R6 cfg_err", 64'(cfg_err), 64'(1));
          chk("R6 rst_req", 64'(rst_req), 64'(1));
        end
      end
    end

    // R7 sticky even after the upset is undone
    do_reset();
    std_load();
    close_load();
    flip(1, 7, 1'b0);
    step();
    flip(1, 7, 1'b0);
    for (int k = 0; k < 3; k++) step();
    chk("R7 cfg_err", 64'(cfg_err), 64'(1));
    chk("R7 rst_req", 64'(rst_req), 64'(1));
    chk("R7 restored value", 64'(cfg_out), 64'(exp_flat()));

    // R10 reset clears the flags
    do_reset();
    chk("R10 cfg_err", 64'(cfg_err), 64'(0));
    chk("R10 rst_req", 64'(rst_req), 64'(0));
    chk("R10 cfg_out", 64'(cfg_out), 64'(0));

    // R8 corruption during loading is reported once armed
    std_load();
    flip(2, 15, 1'b1);
    step();
    step();
    chk("R8 quiet while loading", 64'(cfg_err), 64'(0));
    close_load();
    chk("R8 armed edge", 64'(cfg_err), 64'(0));
    step();
    chk("R8 cfg_err", 64'(cfg_err), 64'(1));
    chk("R8 rst_req", 64'(rst_req), 64'(1));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule